// File: doc/BRIEF.md
# Serial Audio Link Power-Down and Wake Controller

This block sits on the codec side of a five-wire serial audio link. It owns the power-down control/status register. Host writes to that register arrive already decoded from the command and data slots of a frame. Four bits power down analog subsections one by one. A fifth bit shuts down the link itself: after a fixed drain delay the controller drops the enable of the bit clock. The bit clock is modelled as a gate on a free-running reference clock.

Once the link is halted, the frame sync line is treated as an asynchronous input. A warm reset is a SYNC high pulse of at least a minimum width, followed by SYNC going low again. It clears only the link-shutdown bit and restarts the clock after a startup delay. A cold reset through the active-low reset pin clears every bit and then starts the clock the same way. For each subsection, a read-only ready flag reports that its power-down bit has stayed clear for a settle time. All timing is counted in reference-clock cycles.

Top module: `link_pwr_ctrl`

## Requirements
- R1: The register is written only by a write strobe whose address equals `PD_INDEX` (default 0x26). Data bits 8..12 load the subsection bits 0..3 and the link-shutdown bit 4. Bits 8..12 of the readback hold these bits. A write to any other address, and every other data bit, has no effect.
- R2: Readback bits 0..3 are read-only ready flags. Flag i is 0 from the cycle after power-down bit i is set. It becomes 1 once bit i has been clear for `SETTLE` cycles. Writes to bits 0..3 have no effect.
- R3: After an accepted write that sets the link-shutdown bit, `bclk_en` stays high for exactly `HALT_DLY` further clock edges and then falls. It stays low until a warm or cold reset.
- R4: While `link_ready` is low, register writes are ignored, including writes made while the clock is halted.
- R5: A warm reset is a halted-state SYNC high pulse of at least `WAKE_MIN` cycles. `bclk_en` stays low for as long as SYNC remains high. It rises at the (`SYNC_STAGES`+1+`START_DLY`)-th clock edge after SYNC returns low.
- R6: A halted-state SYNC pulse shorter than `WAKE_MIN` cycles is ignored, and the clock stays halted.
- R7: A warm reset clears only the link-shutdown bit. Subsection bits 0..3 and their ready flags keep their values.
- R8: While `cold_rst_n` is low, the readback is all zero and `bclk_en` and `link_ready` are low. After release, `bclk_en` rises at the `START_DLY`-th clock edge, and the ready flags rise `SETTLE` cycles after that release.
- R9: `link_ready` is high only while the clock runs and no halt is pending. It goes low on the edge after the shutdown write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| cold_rst_n | input | 1 | Active-low cold reset pin, sampled on clk |
| wr_en | input | 1 | One-cycle strobe for a decoded register write |
| wr_addr | input | 7 | Register index of the write |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | Frame sync line, asynchronous while halted |
| bclk_en | output | 1 | Bit clock enable |
| link_ready | output | 1 | Link operational, writes accepted |
| rd_data | output | 16 | Power-down register readback |

## Verification
The hardest states to reach are those of the wake handshake. They need a register write that halts the link, a pulse on the asynchronous SYNC line of a chosen width, and then a wait for SYNC to fall. The bench first drives random subsection patterns through the write path so that the state kept across the halt is non-trivial. It then halts the link and sends a pulse one cycle too short, followed by a long pulse. During the long pulse it holds SYNC high for many cycles to show that the clock waits for the falling edge. It counts the exact cycles from the edge to the clock enable, then confirms that the subsection bits and ready flags survived.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

    localparam int LINK_ADDR_W = 7;
    localparam int LINK_DATA_W = 16;
    localparam int PD_FIELD_LSB = 8;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_RUN,
        ST_DRAIN,
        ST_HALTED,
        ST_WAKE_HI,
        ST_START
    } lnk_state_e;

    typedef struct packed {
        logic                   valid;
        logic [LINK_ADDR_W-1:0] addr;
        logic [LINK_DATA_W-1:0] data;
    } reg_wr_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lp_ready_flag.sv
module lp_ready_flag #(
    parameter int SETTLE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    output logic ready
);
    localparam int CW = $clog2(SETTLE + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || pd) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt == CW'(SETTLE - 1)) ready <= 1'b1;
            else                        cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lp_seq.sv
module lp_seq
    import link_pwr_pkg::*;
#(
    parameter int HALT_DLY  = 8,
    parameter int WAKE_MIN  = 4,
    parameter int START_DLY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_pd,
    input  logic sync_s,
    output logic bclk_en,
    output logic link_up,
    output logic warm_clr
);
    localparam int MAXC = max3(HALT_DLY, WAKE_MIN, START_DLY);
    localparam int CW   = $clog2(MAXC + 1);

    lnk_state_e    st;
    logic [CW-1:0] cnt;
    logic          wide_enough;

    assign wide_enough = (cnt >= CW'(WAKE_MIN));
    assign warm_clr    = (st == ST_WAKE_HI) && !sync_s && wide_enough;
    assign bclk_en     = (st == ST_RUN) || (st == ST_DRAIN);
    assign link_up     = (st == ST_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_BOOT;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_BOOT, ST_START: begin
                    if (cnt == CW'(START_DLY - 1)) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (link_pd) begin
                        st  <= ST_DRAIN;
                        cnt <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (cnt == CW'(HALT_DLY - 1)) begin
                        st  <= ST_HALTED;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HALTED: begin
                    if (sync_s) begin
                        st  <= ST_WAKE_HI;
                        cnt <= CW'(1);
                    end
                end
                ST_WAKE_HI: begin
                    if (sync_s) begin
                        if (!wide_enough) cnt <= cnt + 1'b1;
                    end else begin
                        st  <= wide_enough ? ST_START : ST_HALTED;
                        cnt <= '0;
                    end
                end
                default: begin
                    st  <= ST_BOOT;
                    cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import link_pwr_pkg::*;
#(
    parameter int NUM_SUB     = 4,
    parameter int PD_INDEX    = 'h26,
    parameter int HALT_DLY    = 8,
    parameter int WAKE_MIN    = 4,
    parameter int START_DLY   = 6,
    parameter int SETTLE      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   cold_rst_n,
    input  logic                   wr_en,
    input  logic [LINK_ADDR_W-1:0] wr_addr,
    input  logic [LINK_DATA_W-1:0] wr_data,
    input  logic                   sync_in,
    output logic                   bclk_en,
    output logic                   link_ready,
    output logic [LINK_DATA_W-1:0] rd_data
);
    localparam int PD_W = NUM_SUB + 1;

    reg_wr_t          req;
    logic [PD_W-1:0]  pd_q;
    logic [NUM_SUB-1:0] rdy;
    logic             sync_s;
    logic             warm_clr;
    logic             wr_ok;

    assign req   = '{valid: wr_en, addr: wr_addr, data: wr_data};
    assign wr_ok = req.valid && link_ready && (req.addr == LINK_ADDR_W'(PD_INDEX));

    lp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (cold_rst_n),
        .d     (sync_in),
        .q     (sync_s)
    );

    lp_seq #(
        .HALT_DLY  (HALT_DLY),
        .WAKE_MIN  (WAKE_MIN),
        .START_DLY (START_DLY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (cold_rst_n),
        .link_pd  (pd_q[NUM_SUB]),
        .sync_s   (sync_s),
        .bclk_en  (bclk_en),
        .link_up  (link_ready),
        .warm_clr (warm_clr)
    );

    always_ff @(posedge clk) begin
        if (!cold_rst_n)   pd_q          <= '0;
        else if (wr_ok)    pd_q          <= req.data[PD_FIELD_LSB +: PD_W];
        else if (warm_clr) pd_q[NUM_SUB] <= 1'b0;
    end

    for (genvar i = 0; i < NUM_SUB; i++) begin : g_rdy
        lp_ready_flag #(.SETTLE(SETTLE)) u_flag (
            .clk   (clk),
            .rst_n (cold_rst_n),
            .pd    (pd_q[i]),
            .ready (rdy[i])
        );
    end

    always_comb begin
        rd_data                          = '0;
        rd_data[NUM_SUB-1:0]             = rdy;
        rd_data[PD_FIELD_LSB +: PD_W]    = pd_q;
    end
endmodule

// File: rtl/link_pwr_chk.sv
module link_pwr_chk #(
    parameter int NUM_SUB = 4,
    parameter int DW      = 16
) (
    input logic          clk,
    input logic          cold_rst_n,
    input logic          sync_in,
    input logic          bclk_en,
    input logic          link_ready,
    input logic [DW-1:0] rd_data
);
    localparam int PD_LSB = 8;

    // R3
    halt_needs_pd_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $fell(bclk_en) |-> rd_data[PD_LSB + NUM_SUB]);

    // R5
    restart_after_sync_low_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(bclk_en) |-> !sync_in);

    // R7
    restart_clears_link_pd_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(bclk_en) |-> !rd_data[PD_LSB + NUM_SUB]);

    // R9
    ready_needs_clock_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        link_ready |-> bclk_en);

    // R4
    halted_regs_frozen_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!bclk_en && $past(!bclk_en)) |-> $stable(rd_data[PD_LSB +: NUM_SUB]));

    for (genvar i = 0; i < NUM_SUB; i++) begin : g_flag
        // R2
        pd_drops_ready_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
            (rd_data[PD_LSB + i] && $past(rd_data[PD_LSB + i])) |-> !rd_data[i]);
    end
endmodule

bind link_pwr_ctrl link_pwr_chk #(.NUM_SUB(NUM_SUB), .DW(16)) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .sync_in    (sync_in),
    .bclk_en    (bclk_en),
    .link_ready (link_ready),
    .rd_data    (rd_data)
);

// File: tb/test_link_pwr_ctrl.sv
module test_link_pwr_ctrl;
    localparam int HALT_DLY    = 8;
    localparam int WAKE_MIN    = 4;
    localparam int START_DLY   = 6;
    localparam int SETTLE      = 5;
    localparam int SYNC_STAGES = 2;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sync_in = 1'b0;
    logic        bclk_en, link_ready;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    link_pwr_ctrl #(
        .HALT_DLY(HALT_DLY), .WAKE_MIN(WAKE_MIN), .START_DLY(START_DLY),
        .SETTLE(SETTLE), .SYNC_STAGES(SYNC_STAGES)
    ) i_link_pwr_ctrl (
        .clk(clk), .cold_rst_n(cold_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .bclk_en(bclk_en),
        .link_ready(link_ready), .rd_data(rd_data)
    );

    function automatic logic [15:0] exp_status(input logic [4:0] pd);
        return {3'b000, pd, 4'b0000, ~pd[3:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_until(input logic target, output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (bclk_en == target) break;
            n++;
        end
    endtask

    task automatic pulse_sync(input int width);
        @(negedge clk);
        sync_in = 1'b1;
        repeat (width) @(negedge clk);
        sync_in = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [4:0]  pd;
        logic [15:0] d;
        void'($urandom(32'd1234));

        // R8 reset state
        repeat (5) @(negedge clk);
        check(rd_data == 16'h0 && !bclk_en && !link_ready, "R8 reset", rd_data, 0);
        cold_rst_n = 1'b1;
        count_until(1'b1, n);
        check(n == START_DLY - 1, "R8 cold start delay", n, START_DLY - 1);
        repeat (SETTLE) @(negedge clk);
        check(rd_data == 16'h000F, "R8 R2 ready after cold", rd_data, 16'h000F);

        // R1 R2 random subsection patterns
        pd = '0;
        for (int it = 0; it < 20; it++) begin
            d = 16'($urandom);
            d[12] = 1'b0;
            if (it % 4 == 3) begin
                do_write(7'h26 ^ 7'(1 + $urandom % 127), d);
                repeat (SETTLE + 3) @(negedge clk);
                check(rd_data == exp_status(pd), "R1 other address ignored", rd_data, exp_status(pd));
            end else begin
                do_write(7'h26, d);
                pd = d[12:8];
                repeat (SETTLE + 3) @(negedge clk);
                check(rd_data == exp_status(pd), "R1 R2 write readback", rd_data, exp_status(pd));
            end
        end

        // R2 low nibble read-only
        do_write(7'h26, 16'h0500);
        repeat (SETTLE + 3) @(negedge clk);
        do_write(7'h26, 16'h050F);
        @(negedge clk);
        check(rd_data == exp_status(5'h05), "R2 ready bits read-only", rd_data, exp_status(5'h05));

        // R3 halt
        do_write(7'h26, 16'h1500);
        check(rd_data[12] == 1'b1, "R1 link bit set", rd_data[12], 1);
        count_until(1'b0, n);
        check(n == HALT_DLY, "R3 drain length", n, HALT_DLY);
        check(!link_ready, "R9 not ready while halted", link_ready, 0);

        // R4 write while halted
        do_write(7'h26, 16'h0A00);
        repeat (10) @(negedge clk);
        check(rd_data == exp_status(5'h15), "R4 halted write ignored", rd_data, exp_status(5'h15));
        check(!bclk_en, "R3 stays halted", bclk_en, 0);

        // R6 short pulse
        pulse_sync(WAKE_MIN - 1);
        repeat (40) @(negedge clk);
        check(!bclk_en, "R6 short pulse ignored", bclk_en, 0);

        // R5 long pulse, clock waits for low
        @(negedge clk);
        sync_in = 1'b1;
        repeat (WAKE_MIN + 30) @(negedge clk);
        check(!bclk_en, "R5 no restart while sync high", bclk_en, 0);
        sync_in = 1'b0;
        count_until(1'b1, n);
        check(n == START_DLY + SYNC_STAGES, "R5 restart delay", n, START_DLY + SYNC_STAGES);
        check(rd_data == exp_status(5'h05), "R7 warm keeps subsections", rd_data, exp_status(5'h05));
        @(negedge clk);
        check(link_ready, "R9 ready after restart", link_ready, 1);

        // R3 again, then minimum accepted pulse
        do_write(7'h26, 16'h1300);
        count_until(1'b0, n);
        check(n == HALT_DLY, "R3 second drain", n, HALT_DLY);
        pulse_sync(WAKE_MIN);
        count_until(1'b1, n);
        check(n == START_DLY + SYNC_STAGES, "R5 minimum pulse accepted", n, START_DLY + SYNC_STAGES);
        repeat (SETTLE + 2) @(negedge clk);
        check(rd_data == exp_status(5'h03), "R7 warm clears link bit only", rd_data, exp_status(5'h03));

        // R8 cold reset clears everything
        @(negedge clk);
        cold_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_data == 16'h0 && !bclk_en, "R8 cold clears", rd_data, 0);
        cold_rst_n = 1'b1;
        count_until(1'b1, n);
        check(n == START_DLY - 1, "R8 cold restart", n, START_DLY - 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule